// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Select

This block accumulates activity seen on a single external input into a 16-bit count. In event mode it adds one for every edge of the chosen polarity. In gated mode it adds one per fixed internal tick (one every 64 clocks by default) for as long as the input stays at its active level. The input first passes through a two-flop synchroniser, and all edge detection uses the synchronised copy.

A seven-bit control word sets the behaviour: run enable, mode, polarity, a two-bit clock-select field and two interrupt enables. Software can read and write the count, and a write in the same cycle as an increment wins. An overflow flag records a wrap of the count, and an input flag records a counted edge (event mode) or the end of a gate (gated mode). Each flag stays set until a 1 is written to its clear bit. The interrupt request combines the flags with their enables.

The block also produces a one-cycle tick enable for an external main timer. The clock-select field chooses its source: the external prescaler tick, every increment, every carry out of the low byte of the count, or every wrap of the full count.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count, the control word, both flags, the interrupt request and the timer tick (with the external prescaler tick low) are all zero.
- R2: While the run bit (control bit 0) is 0, the count holds, neither flag is set, and the timer tick is 0 for every clock-select value other than 00.
- R3: With control bit 1 = 0 (event mode), each edge of the synchronised input adds one to the count. Control bit 2 selects the edge: 1 counts rising edges and 0 counts falling edges.
- R4: With control bit 1 = 1 (gated mode), the count rises by one every 64 clocks while the synchronised input equals control bit 2. The 64-clock divider restarts from zero whenever the block is stopped or out of gated mode, so after entering gated mode with the gate held active, the count after L clocks is floor(L/64).
- R5: The input flag (evt_flag_o) is set by each counted edge in event mode. In gated mode it is set by the trailing edge of the gate, and the leading edge does not set it.
- R6: An increment from 0xFFFF wraps the count to 0x0000 and sets the overflow flag (ovf_flag_o).
- R7: Both flags stay set until a 1 is written to their clear bit: flag_clr_i bit 0 clears the overflow flag and bit 1 clears the input flag. Clearing one flag leaves the other unchanged.
- R8: irq_o is high exactly when (overflow flag AND control bit 5) OR (input flag AND control bit 6).
- R9: A count write takes effect on the next clock and takes priority over an increment in the same cycle. A suppressed increment neither advances the count nor sets the overflow flag.
- R10: With clock select (control bits 4:3) = 00, the timer tick follows tick_presc_i.
- R11: With clock select = 01, the timer tick pulses once for each applied increment.
- R12: With clock select = 10, the timer tick pulses on each increment that carries out of the low 8 bits of the count. With clock select = 11, it pulses on each increment that wraps the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous external input |
| tick_presc_i | input | 1 | External timer prescaler tick enable |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 7 | Control write data: 0 run, 1 gated, 2 polarity, 4:3 clock select, 5 overflow IE, 6 input IE |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 16 | Count write data |
| flag_clr_i | input | 2 | Write-1-to-clear: bit 0 overflow flag, bit 1 input flag |
| cnt_o | output | 16 | Current count |
| ctrl_o | output | 7 | Current control word |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| evt_flag_o | output | 1 | Sticky input flag |
| irq_o | output | 1 | Interrupt request |
| tmr_tick_o | output | 1 | Selected main timer tick enable |

## Verification
The hardest case to reach from the ports is a count write colliding with a gated increment. The 64-clock divider is not visible, so the bench holds the count write strobe high for several full divider periods with the gate active. This guarantees several collisions, including collisions with 0xFFFF loaded, where an overflow must not appear. The gated sweep starts the divider at a known instant by entering gated mode through a control write. It then samples at lengths on either side of each 64-clock boundary.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
   localparam int CTRL_W = 7;

   typedef enum logic [1:0] {
      SEL_PRESC    = 2'b00,
      SEL_ACC      = 2'b01,
      SEL_ACC_LO   = 2'b10,
      SEL_ACC_FULL = 2'b11
   } clk_sel_e;

   // packed: first member is the most significant bit (bit 6)
   typedef struct packed {
      logic     evt_ie;
      logic     ovf_ie;
      clk_sel_e clk_sel;
      logic     edge_pol;
      logic     gated;
      logic     run;
   } ctrl_t;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);
   // sh[STAGES-1:0] is the synchroniser chain, sh[STAGES] the previous level
   logic [STAGES:0] sh;

   if (STAGES < 2) begin : g_bad_stages
      $error("pacc_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], din};
   end

   assign lvl  = sh[STAGES-1];
   assign rise =  sh[STAGES-1] & ~sh[STAGES];
   assign fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/pacc_gate_div.sv
module pacc_gate_div #(
   parameter int GATE_DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   if (GATE_DIV < 1) begin : g_bad_div
      $error("pacc_gate_div: GATE_DIV must be positive");
   end

   if (GATE_DIV == 1) begin : g_direct
      assign tick = ~clr;
   end else begin : g_count
      localparam int PW = $clog2(GATE_DIV);
      localparam logic [PW-1:0] LAST = PW'(GATE_DIV - 1);
      logic [PW-1:0] ph;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          ph <= '0;
         else if (clr)        ph <= '0;
         else if (ph == LAST) ph <= '0;
         else                 ph <= ph + 1'b1;
      end

      assign tick = ~clr & (ph == LAST);
   end
endmodule

// File: rtl/pacc_clksel.sv
module pacc_clksel
   import pacc_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int LO_W  = 8
) (
   input  clk_sel_e         sel,
   input  logic             presc_tick,
   input  logic             inc,
   input  logic [CNT_W-1:0] cnt,
   output logic             tick
);
   if (LO_W < 1 || LO_W >= CNT_W) begin : g_bad_lo
      $error("pacc_clksel: LO_W must lie in 1..CNT_W-1");
   end

   logic lo_carry, full_carry;
   assign lo_carry   = inc & (&cnt[LO_W-1:0]);
   assign full_carry = inc & (&cnt);

   always_comb begin
      unique case (sel)
         SEL_PRESC:  tick = presc_tick;
         SEL_ACC:    tick = inc;
         SEL_ACC_LO: tick = lo_carry;
         default:    tick = full_carry;
      endcase
   end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
   import pacc_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int GATE_DIV = 64,
   parameter int LO_W     = 8,
   parameter int SYNC_N   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_i,
   input  logic              tick_presc_i,
   input  logic              ctrl_we_i,
   input  logic [CTRL_W-1:0] ctrl_wdata_i,
   input  logic              cnt_we_i,
   input  logic [CNT_W-1:0]  cnt_wdata_i,
   input  logic [1:0]        flag_clr_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              ovf_flag_o,
   output logic              evt_flag_o,
   output logic              irq_o,
   output logic              tmr_tick_o
);
   if (CNT_W < 2) begin : g_bad_w
      $error("pulse_accum: CNT_W must be at least 2");
   end

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q, evt_q;
   logic             lvl, rise, fall;
   logic             gate_tick;
   logic             act_lvl, cnt_edge, trail_edge;
   logic             acc_tick, inc, wrap, evt_set;

   pacc_sync #(.STAGES(SYNC_N)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_i),
      .lvl  (lvl),
      .rise (rise),
      .fall (fall)
   );

   pacc_gate_div #(.GATE_DIV(GATE_DIV)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (~(ctrl_q.run & ctrl_q.gated)),
      .tick (gate_tick)
   );

   assign act_lvl    = (lvl == ctrl_q.edge_pol);
   assign cnt_edge   = ctrl_q.edge_pol ? rise : fall;
   assign trail_edge = ctrl_q.edge_pol ? fall : rise;

   assign acc_tick = ctrl_q.run &
                     (ctrl_q.gated ? (gate_tick & act_lvl) : cnt_edge);
   assign inc      = acc_tick & ~cnt_we_i;
   assign wrap     = inc & (&cnt_q);
   assign evt_set  = ctrl_q.run & (ctrl_q.gated ? trail_edge : cnt_edge);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cnt_q  <= '0;
         ovf_q  <= 1'b0;
         evt_q  <= 1'b0;
      end else begin
         if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_wdata_i);
         if (cnt_we_i)  cnt_q  <= cnt_wdata_i;
         else if (inc)  cnt_q  <= cnt_q + 1'b1;
         ovf_q <= wrap    | (ovf_q & ~flag_clr_i[0]);
         evt_q <= evt_set | (evt_q & ~flag_clr_i[1]);
      end
   end

   pacc_clksel #(.CNT_W(CNT_W), .LO_W(LO_W)) u_sel (
      .sel       (ctrl_q.clk_sel),
      .presc_tick(tick_presc_i),
      .inc       (inc),
      .cnt       (cnt_q),
      .tick      (tmr_tick_o)
   );

   assign cnt_o      = cnt_q;
   assign ctrl_o     = ctrl_q;
   assign ovf_flag_o = ovf_q;
   assign evt_flag_o = evt_q;
   assign irq_o      = (ovf_q & ctrl_q.ovf_ie) | (evt_q & ctrl_q.evt_ie);
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_we_i,
   input logic [CNT_W-1:0] cnt_wdata_i,
   input logic             ovf_clr_i,
   input logic [CNT_W-1:0] cnt_o,
   input logic             run_i,
   input logic [1:0]       sel_i,
   input logic             ovf_flag_o,
   input logic             tmr_tick_o
);
   AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !cnt_we_i) |=> $stable(cnt_o)); // R2

   AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && sel_i != 2'b00) |-> !tmr_tick_o); // R2

   AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_we_i |=> (cnt_o == $past(cnt_o) || cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R3

   AST_WRAP_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag_o) |-> (cnt_o == '0)); // R6

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o); // R7

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we_i |=> (cnt_o == $past(cnt_wdata_i))); // R9
endmodule

bind pulse_accum pacc_checker #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cnt_we_i   (cnt_we_i),
   .cnt_wdata_i(cnt_wdata_i),
   .ovf_clr_i  (flag_clr_i[0]),
   .cnt_o      (cnt_o),
   .run_i      (ctrl_o[0]),
   .sel_i      (ctrl_o[4:3]),
   .ovf_flag_o (ovf_flag_o),
   .tmr_tick_o (tmr_tick_o)
);

// File: tb/tb_pulse_accum.sv
`timescale 1ns/1ps
module tb_pulse_accum;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_i = 1'b0;
   logic        tick_presc_i = 1'b0;
   logic        ctrl_we_i = 1'b0;
   logic [6:0]  ctrl_wdata_i = '0;
   logic        cnt_we_i = 1'b0;
   logic [15:0] cnt_wdata_i = '0;
   logic [1:0]  flag_clr_i = '0;
   logic [15:0] cnt_o;
   logic [6:0]  ctrl_o;
   logic        ovf_flag_o, evt_flag_o, irq_o, tmr_tick_o;

   int checks = 0, errors = 0;
   int tk = 0, pk = 0, ph = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pulse_accum dut (.*);

   // sample the tick half a cycle before the edge that would consume it
   always begin
      @(negedge clk);
      tick_presc_i = (ph % 3 == 0);
      ph++;
      #1;
      if (tmr_tick_o)   tk++;
      if (tick_presc_i) pk++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctrl(input logic [6:0] v);
      @(negedge clk); ctrl_wdata_i = v; ctrl_we_i = 1'b1;
      @(negedge clk); ctrl_we_i = 1'b0;
   endtask

   task automatic wr_cnt(input logic [15:0] v);
      @(negedge clk); cnt_wdata_i = v; cnt_we_i = 1'b1;
      @(negedge clk); cnt_we_i = 1'b0;
   endtask

   task automatic clr(input logic [1:0] m);
      @(negedge clk); flag_clr_i = m;
      @(negedge clk); flag_clr_i = 2'b00;
   endtask

   // ctrl word: bit0 run, bit1 gated, bit2 polarity, 4:3 select, 5 ovf IE, 6 evt IE
   function automatic logic [6:0] cw(bit run, bit gated, bit pol, logic [1:0] sel, bit oie, bit eie);
      return {eie, oie, sel, pol, gated, run};
   endfunction

   task automatic pulse(input bit pol);
      pin_i = pol;  step(3);
      pin_i = ~pol; step(3);
   endtask

   initial begin
      #800000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step(3);
      // R1 reset state, sampled while reset is still asserted
      chk("R1 cnt", cnt_o, 0);
      chk("R1 ctrl", ctrl_o, 0);
      chk("R1 flags/irq", {ovf_flag_o, evt_flag_o, irq_o}, 0);
      rst_n = 1'b1;
      step(2);
      chk("R1 ctrl after release", ctrl_o, 0);

      // R2: stopped, toggling input changes nothing
      wr_cnt(16'h0055);
      wr_ctrl(cw(0, 0, 1, 2'b01, 1, 1));
      tk = 0;
      for (int i = 0; i < 5; i++) pulse(1'b1);
      chk("R2 count held", cnt_o, 16'h0055);
      chk("R2 no flags", {ovf_flag_o, evt_flag_o}, 0);
      chk("R2 no timer tick", tk, 0);

      // R3/R5/R11 event-mode sweep over both polarities and several lengths
      for (int pol = 0; pol < 2; pol++) begin
         for (int n = 1; n <= 9; n += 4) begin
            wr_ctrl(0);
            pin_i = ~pol[0]; step(4);
            wr_cnt(16'h0000);
            clr(2'b11);
            wr_ctrl(cw(1, 0, pol[0], 2'b01, 0, 0));
            tk = 0;
            for (int k = 0; k < n; k++) pulse(pol[0]);
            chk("R3 edge count", cnt_o, n);
            chk("R11 tick per increment", tk, n);
            chk("R5 event flag", evt_flag_o, 1);
         end
         // R3 opposite edge alone does not count
         wr_cnt(16'h0000);
         pin_i = pol[0]; step(4);
         chk("R3 counting edge", cnt_o, 1);
         pin_i = ~pol[0]; step(4);
         chk("R3 other edge ignored", cnt_o, 1);
      end

      // R4/R5 gated sweep across 64-cycle boundaries, both polarities
      for (int pol = 0; pol < 2; pol++) begin
         for (int j = 0; j < 6; j++) begin
            int lens[6] = '{63, 64, 65, 127, 128, 300};
            wr_ctrl(0);
            pin_i = pol[0]; step(4);
            wr_cnt(16'h0000);
            clr(2'b11);
            wr_ctrl(cw(1, 1, pol[0], 2'b00, 0, 0));
            step(lens[j]);
            chk("R4 gated count", cnt_o, lens[j] / 64);
            chk("R5 no flag on leading edge", evt_flag_o, 0);
            pin_i = ~pol[0]; step(5);
            chk("R5 flag on trailing edge", evt_flag_o, 1);
         end
      end

      // R4 inactive level does not count
      wr_ctrl(0);
      pin_i = 1'b0; step(4);
      wr_cnt(16'h0000);
      wr_ctrl(cw(1, 1, 1, 2'b00, 0, 0));
      step(200);
      chk("R4 inactive gate", cnt_o, 0);

      // R9 write held across gated increments wins
      pin_i = 1'b1; step(4);
      @(negedge clk); cnt_wdata_i = 16'h1234; cnt_we_i = 1'b1;
      step(200);
      chk("R9 write priority", cnt_o, 16'h1234);
      clr(2'b11);
      @(negedge clk); cnt_wdata_i = 16'hFFFF;
      step(200);
      cnt_we_i = 1'b0;
      chk("R9 held FFFF", cnt_o, 16'hFFFF);
      chk("R9 no overflow when suppressed", ovf_flag_o, 0);
      wr_ctrl(0);

      // R12 low-byte carry select
      pin_i = 1'b0; step(4);
      wr_cnt(16'h00F0);
      wr_ctrl(cw(1, 0, 1, 2'b10, 0, 0));
      tk = 0;
      for (int k = 0; k < 40; k++) pulse(1'b1);
      chk("R12 count", cnt_o, 16'h0118);
      chk("R12 low carry ticks", tk, 1);

      // R6/R12 full wrap select
      clr(2'b11);
      wr_cnt(16'hFFF0);
      wr_ctrl(cw(1, 0, 1, 2'b11, 1, 0));
      tk = 0;
      for (int k = 0; k < 20; k++) pulse(1'b1);
      chk("R6 wrapped count", cnt_o, 16'h0004);
      chk("R6 overflow flag", ovf_flag_o, 1);
      chk("R12 full wrap ticks", tk, 1);
      chk("R8 irq from overflow", irq_o, 1);

      // R7/R8 flag sticky, selective clear, irq masking
      step(50);
      chk("R7 sticky", {ovf_flag_o, evt_flag_o}, 2'b11);
      wr_ctrl(cw(0, 0, 1, 2'b00, 0, 0));
      chk("R8 masked", irq_o, 0);
      wr_ctrl(cw(0, 0, 1, 2'b00, 0, 1));
      chk("R8 evt enable", irq_o, 1);
      clr(2'b10);
      chk("R7 selective clear", {ovf_flag_o, evt_flag_o}, 2'b10);
      chk("R8 evt cleared", irq_o, 0);
      wr_ctrl(cw(0, 0, 1, 2'b00, 1, 0));
      chk("R8 ovf enable", irq_o, 1);
      clr(2'b01);
      chk("R7 overflow cleared", {ovf_flag_o, irq_o}, 0);

      // R10 prescaler pass-through
      wr_ctrl(cw(1, 0, 1, 2'b00, 0, 0));
      tk = 0; pk = 0;
      step(90);
      chk("R10 prescaler ticks", tk, pk);
      chk("R10 nonzero", (pk > 0), 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule